// File: doc/BRIEF.md
# Fault-Steering Direct-Mapped Cache

This block is a direct-mapped cache in which every row of the data and tag arrays holds several blocks. Manufacturing or operating-point faults can leave individual blocks unusable. A fault map outside the block flags them. For each request the block asks that map, in the same cycle, which blocks of the addressed row are faulty. When the requested block is bad, the block quietly redirects the access to a healthy block of the same row. The processor keeps issuing ordinary addresses and never learns that the cache has shrunk.

Several addresses can now share one physical block. To stop them from aliasing, the tag written into the tag array is widened by the requested column bits. Two addresses that differ only in column, but land on the same substitute block, then compare unequal and miss. A miss fetches the whole block from the next memory level over a request/acknowledge handshake. A hit returns one 32-bit word chosen by the byte offset. Writes merge one word into the block. A write miss fetches the block first and then merges the word.

The control is a four-state machine:
- **ST_IDLE** accepts a request. It goes to ST_PROBE for a usable row, or straight to ST_REPLY when every block of the row is faulty.
- **ST_PROBE** compares the tag. It goes to ST_REPLY on a hit and to ST_FILL on a miss.
- **ST_FILL** waits for the refill acknowledge and then goes to ST_REPLY.
- **ST_REPLY** presents the response for one cycle and returns to ST_IDLE.

Top module: `remap_cache`

## Requirements
- R1: Address fields, with default parameters, are: tag = addr[31:16], row = addr[15:7], column = addr[6:5], word = addr[4:2]. A miss requests the block at the address with bits [4:0] cleared and answers a read with the word that the refilled block holds at that word position.
- R2: After a block is refilled, an access with the same tag, row and column hits, starts no refill, and a read returns the stored word.
- R3: Every block is invalid after reset, so the first access to any block misses, including a block that held data before the reset.
- R4: When the fault-mask bit of the requested column is 0, that column's own block is used, and blocks of other columns are not disturbed.
- R5: When fault-mask bit c is 1, let k be the number of faulty columns below c and h the number of healthy columns in the row. The access uses the (k mod h)-th healthy column, counting healthy columns upward from 0.
- R6: The tag array stores {address tag, requested column}. An access whose substitute block holds a different requested column misses and refills, even when the address tags are equal.
- R7: A write hit replaces only the addressed 32-bit word of the block. Later reads return the new word, and the other words keep their values.
- R8: A write miss refills the block, merges the written word into it, and stores the widened tag. This also applies when the target is a substitute block shared with another column.
- R9: An access to a row whose four mask bits are all 1 completes with rsp_hit = 0 and no refill. It sets cache_unusable, which stays 1 until reset.
- R10: rsp_valid is a one-cycle pulse. A hit answers 2 cycles after the request is accepted. A dead-row access answers 1 cycle after acceptance. A miss answers 1 cycle after mem_ack.
- R11: mem_req stays high with a stable mem_addr until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block is in ST_IDLE |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Access hit in the cache |
| rsp_rdata | output | 32 | Read word (reads only) |
| fm_row | output | 9 | Row index presented to the fault map |
| fm_mask | input | 4 | Faulty-block flags of that row, bit i = column i, same cycle |
| mem_req | output | 1 | Refill request to the next level |
| mem_addr | output | 32 | Block-aligned refill address |
| mem_ack | input | 1 | Refill data valid |
| mem_rdata | input | 256 | Refill block, word i in bits [32i+31:32i] |
| cache_unusable | output | 1 | Sticky flag: a row with no healthy block was accessed |

## Verification
The assertions assume several things about the inputs:
- The fault mask for a row is stable while a request to that row is accepted.
- mem_ack arrives only while mem_req is high, as a single-cycle pulse.
- A new request is offered only while req_ready is high.

The stimulus respects all of this. The fault map is a fixed function of fm_row. The memory model acknowledges a fixed number of cycles after it sees mem_req and drops the acknowledge on the next cycle. Each request is issued only after the previous response pulse has ended. The mask patterns cover one, two, three and four faulty blocks per row, with faulty columns both below and above the healthy ones, so the substitution order is visible through which accesses alias.

// File: rtl/rcache_pkg.sv
package rcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_FILL,
        ST_REPLY
    } cache_state_t;

endpackage

// File: rtl/blk_remap.sv
// Chooses the physical column for an access from the row's fault flags.
// The k-th faulty column (ascending) goes to the (k mod h)-th healthy column.
module blk_remap #(
    parameter int COLS  = 4,
    parameter int COL_W = 2
) (
    input  logic [COLS-1:0]  fault_mask,
    input  logic [COL_W-1:0] want_col,
    output logic [COL_W-1:0] use_col,
    output logic             row_dead
);

    localparam int CNT_W = $clog2(COLS + 1);

    logic [CNT_W-1:0] rank;
    logic [CNT_W-1:0] healthy;
    logic [CNT_W-1:0] pick;
    logic [CNT_W-1:0] seen;

    always_comb begin
        rank    = '0;
        healthy = '0;
        for (int i = 0; i < COLS; i++) begin
            if (!fault_mask[i]) healthy = healthy + CNT_W'(1);
            if (fault_mask[i] && (i < int'(want_col))) rank = rank + CNT_W'(1);
        end
        pick = (healthy == '0) ? '0 : (rank % healthy);
    end

    always_comb begin
        seen    = '0;
        use_col = want_col;
        for (int i = 0; i < COLS; i++) begin
            if (!fault_mask[i]) begin
                if (fault_mask[want_col] && (seen == pick)) use_col = COL_W'(i);
                seen = seen + CNT_W'(1);
            end
        end
    end

    assign row_dead = (healthy == '0);

endmodule

// File: rtl/blk_store.sv
// Behavioural data, tag and valid arrays indexed by {row, physical column}.
module blk_store #(
    parameter int NBLK  = 2048,
    parameter int IDX_W = 11,
    parameter int BLK_W = 256,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BLK_W-1:0] rd_data,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BLK_W-1:0] wr_data,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [BLK_W-1:0] data_mem [NBLK];
    logic [TAG_W-1:0] tag_mem  [NBLK];
    logic [NBLK-1:0]  vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_idx] <= wr_data;
            tag_mem[wr_idx]  <= wr_tag;
        end
    end

    assign rd_data  = data_mem[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = vld_q[rd_idx];

    // R2: a written block is valid on the following cycle
    assert_valid_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/remap_cache.sv
module remap_cache #(
    parameter int ADDR_W    = 32,
    parameter int ROWS      = 512,
    parameter int COLS      = 4,
    parameter int BLK_BYTES = 32,
    parameter int WORD_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [WORD_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [WORD_W-1:0]         rsp_rdata,
    output logic [$clog2(ROWS)-1:0]   fm_row,
    input  logic [COLS-1:0]           fm_mask,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_ack,
    input  logic [BLK_BYTES*8-1:0]    mem_rdata,
    output logic                      cache_unusable
);
    import rcache_pkg::*;

    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int WSEL_W = $clog2(BLK_BYTES * 8 / WORD_W);
    localparam int BYTE_W = OFF_W - WSEL_W;
    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int TAG_W  = ADDR_W - ROW_W - COL_W - OFF_W;
    localparam int WTAG_W = TAG_W + COL_W;
    localparam int BLK_W  = BLK_BYTES * 8;
    localparam int IDX_W  = ROW_W + COL_W;
    localparam int NBLK   = ROWS * COLS;

    // live address fields
    logic [TAG_W-1:0]  a_tag;
    logic [ROW_W-1:0]  a_row;
    logic [COL_W-1:0]  a_col;
    logic [WSEL_W-1:0] a_word;
    logic              unused_low_bits;

    assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign a_row  = req_addr[OFF_W+COL_W +: ROW_W];
    assign a_col  = req_addr[OFF_W +: COL_W];
    assign a_word = req_addr[BYTE_W +: WSEL_W];
    assign unused_low_bits = ^req_addr[BYTE_W-1:0];
    assign fm_row = a_row;

    logic [COL_W-1:0] live_subst;
    logic             live_dead;

    blk_remap #(.COLS(COLS), .COL_W(COL_W)) u_remap (
        .fault_mask (fm_mask),
        .want_col   (a_col),
        .use_col    (live_subst),
        .row_dead   (live_dead)
    );

    // latched request
    cache_state_t      state, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  subst_q;
    logic [WSEL_W-1:0] word_q;
    logic              we_q;
    logic [WORD_W-1:0] wdata_q;
    logic [COLS-1:0]   mask_q;
    logic              hit_q;
    logic [WORD_W-1:0] rdata_q;
    logic              unusable_q;

    // array interface
    logic [BLK_W-1:0]  rd_data;
    logic [WTAG_W-1:0] rd_tag;
    logic              rd_valid;
    logic              wr_en;
    logic [BLK_W-1:0]  base_blk;
    logic [BLK_W-1:0]  new_blk;
    logic [IDX_W-1:0]  blk_idx;
    logic [WTAG_W-1:0] want_tag;
    logic              probe_hit;

    assign blk_idx   = {row_q, subst_q};
    assign want_tag  = {tag_q, col_q};
    assign probe_hit = rd_valid && (rd_tag == want_tag);

    blk_store #(.NBLK(NBLK), .IDX_W(IDX_W), .BLK_W(BLK_W), .TAG_W(WTAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (blk_idx),
        .rd_data  (rd_data),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .wr_en    (wr_en),
        .wr_idx   (blk_idx),
        .wr_data  (new_blk),
        .wr_tag   (want_tag)
    );

    // word merge for write hits and refills
    always_comb begin
        base_blk = (state == ST_PROBE) ? rd_data : mem_rdata;
        new_blk  = base_blk;
        if (we_q) new_blk[int'(word_q)*WORD_W +: WORD_W] = wdata_q;
    end

    assign wr_en = ((state == ST_PROBE) && probe_hit && we_q) ||
                   ((state == ST_FILL) && mem_ack);

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_d = live_dead ? ST_REPLY : ST_PROBE;
            ST_PROBE: state_d = probe_hit ? ST_REPLY : ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // request capture and response data
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q      <= '0;
            row_q      <= '0;
            col_q      <= '0;
            subst_q    <= '0;
            word_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            mask_q     <= '0;
            hit_q      <= 1'b0;
            rdata_q    <= '0;
            unusable_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    tag_q   <= a_tag;
                    row_q   <= a_row;
                    col_q   <= a_col;
                    subst_q <= live_subst;
                    word_q  <= a_word;
                    we_q    <= req_write;
                    wdata_q <= req_wdata;
                    mask_q  <= fm_mask;
                    hit_q   <= 1'b0;
                    rdata_q <= '0;
                    if (live_dead) unusable_q <= 1'b1;
                end
                ST_PROBE: if (probe_hit) begin
                    hit_q   <= 1'b1;
                    rdata_q <= we_q ? '0 : rd_data[int'(word_q)*WORD_W +: WORD_W];
                end
                ST_FILL: if (mem_ack) begin
                    hit_q   <= 1'b0;
                    rdata_q <= we_q ? '0 : mem_rdata[int'(word_q)*WORD_W +: WORD_W];
                end
                ST_REPLY: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready      = (state == ST_IDLE);
        rsp_valid      = (state == ST_REPLY);
        rsp_hit        = hit_q;
        rsp_rdata      = rdata_q;
        mem_req        = (state == ST_FILL);
        mem_addr       = {tag_q, row_q, col_q, {OFF_W{1'b0}}};
        cache_unusable = unusable_q;
    end

    // R10: response is a single-cycle pulse
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R11: refill request held with a steady address until acknowledged
    assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: the unusable flag never falls outside reset
    assert_unusable_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        cache_unusable |=> cache_unusable);

    // R9: a dead row never starts a refill
    assert_dead_no_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && live_dead) |=> !mem_req);

    // R5: the chosen physical block is flagged healthy
    assert_subst_healthy_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROBE) |-> !mask_q[subst_q]);

    // R4: a healthy requested column is used unchanged
    assert_healthy_kept_R4: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PROBE) && !mask_q[col_q]) |-> (subst_q == col_q));

endmodule

// File: tb/sim_remap_cache.sv
`timescale 1ns/1ps
module sim_remap_cache;

    localparam int MEM_LAT = 2;
    localparam logic [15:0] TA = 16'h0012;
    localparam logic [15:0] TB = 16'h0034;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        hit;
        logic        use_mw;
        logic [31:0] data;
    } vec_t;

    function automatic logic [31:0] ad(input logic [15:0] t, input int r, input int c, input int w);
        return {t, 9'(r), 2'(c), 3'(w), 2'b00};
    endfunction

    function automatic vec_t vr(input logic [31:0] a, input logic h);
        return '{we: 1'b0, addr: a, wdata: 32'h0, hit: h, use_mw: 1'b1, data: 32'h0};
    endfunction

    function automatic vec_t vrd(input logic [31:0] a, input logic [31:0] d);
        return '{we: 1'b0, addr: a, wdata: 32'h0, hit: 1'b1, use_mw: 1'b0, data: d};
    endfunction

    function automatic vec_t vw(input logic [31:0] a, input logic [31:0] d, input logic h);
        return '{we: 1'b1, addr: a, wdata: d, hit: h, use_mw: 1'b0, data: 32'h0};
    endfunction

    // fault map: row 5 -> 0100, 6 -> 0110, 8 -> 1011, 9 -> 1111, 10 -> 0101
    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        vr(ad(TA, 1, 0, 3), 1'b0),                 // R1 cold miss
        vr(ad(TA, 1, 0, 5), 1'b1),                 // R2 hit after refill
        vr(ad(TA, 1, 1, 0), 1'b0),                 // R4 neighbour column own block
        vr(ad(TA, 1, 0, 3), 1'b1),                 // R4 column 0 undisturbed
        vw(ad(TA, 1, 0, 2), 32'hDEADBEEF, 1'b1),   // R7 write hit
        vrd(ad(TA, 1, 0, 2), 32'hDEADBEEF),        // R7 new word
        vr(ad(TA, 1, 0, 3), 1'b1),                 // R7 other word kept
        vr(ad(TA, 5, 0, 1), 1'b0),                 // R4 row 5 col 0
        vr(ad(TA, 5, 2, 1), 1'b0),                 // R6 col 2 -> block 0 alias miss
        vr(ad(TA, 5, 2, 4), 1'b1),                 // R5 substitute hit
        vr(ad(TA, 5, 0, 1), 1'b0),                 // R6 col 0 evicted by alias
        vr(ad(TA, 5, 3, 0), 1'b0),                 // R4 col 3 own block
        vr(ad(TA, 5, 0, 1), 1'b1),                 // R4 col 0 survives
        vr(ad(TA, 6, 1, 0), 1'b0),                 // R5 col 1 -> block 0
        vr(ad(TA, 6, 2, 0), 1'b0),                 // R5 col 2 -> block 3
        vr(ad(TA, 6, 1, 0), 1'b1),                 // R5 col 1 not shared with col 2
        vr(ad(TA, 6, 3, 0), 1'b0),                 // R6 col 3 shares block 3
        vr(ad(TA, 6, 2, 0), 1'b0),                 // R6 col 2 evicted
        vr(ad(TA, 8, 0, 0), 1'b0),                 // R5 single healthy block
        vr(ad(TA, 8, 3, 0), 1'b0),                 // R5 col 3 -> block 2
        vr(ad(TA, 8, 1, 0), 1'b0),                 // R5 col 1 -> block 2
        vr(ad(TA, 8, 1, 7), 1'b1),                 // R5 hit on shared block
        vr(ad(TA, 10, 0, 0), 1'b0),                // R5 col 0 -> block 1
        vr(ad(TA, 10, 1, 0), 1'b0),                // R6 col 1 shares block 1
        vr(ad(TA, 10, 0, 0), 1'b0),                // R6 col 0 evicted
        vw(ad(TA, 11, 2, 6), 32'h12345678, 1'b0),  // R8 write miss refills
        vrd(ad(TA, 11, 2, 6), 32'h12345678),       // R8 merged word
        vr(ad(TA, 11, 2, 5), 1'b1),                // R8 rest from refill
        vw(ad(TA, 5, 2, 3), 32'hCAFEF00D, 1'b0),   // R8 write to shared substitute
        vrd(ad(TA, 5, 2, 3), 32'hCAFEF00D),        // R8 overwritten
        vr(ad(TA, 5, 0, 3), 1'b0),                 // R8 widened tag replaced
        vr(ad(TB, 1, 0, 3), 1'b0),                 // R1 tag conflict miss
        vr(ad(TB, 1, 0, 3), 1'b1)                  // R2 new tag hits
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [31:0]  rsp_rdata;
    logic [8:0]   fm_row;
    logic [3:0]   fm_mask;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rdata = '0;
    logic         cache_unusable;

    int n_tests = 0;
    int n_fail  = 0;
    int wait_cnt = 0;

    always #4 clk = ~clk;

    function automatic logic [3:0] fmap(input logic [8:0] r);
        case (r)
            9'd5:    return 4'b0100;
            9'd6:    return 4'b0110;
            9'd8:    return 4'b1011;
            9'd9:    return 4'b1111;
            9'd10:   return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] mw(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [255:0] mem_blk(input logic [31:0] a);
        logic [255:0] b;
        for (int w = 0; w < 8; w++) b[w*32 +: 32] = mw({a[31:5], 5'b0} + 32'(w * 4));
        return b;
    endfunction

    assign fm_mask = fmap(fm_row);

    remap_cache u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .fm_row(fm_row), .fm_mask(fm_mask),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cache_unusable(cache_unusable)
    );

    // next-level memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == MEM_LAT) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_blk(mem_addr);
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic hit, output logic [31:0] rd, output logic filled,
                          output logic [31:0] faddr, output int lat, output logic pulse_ok);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        filled = 1'b0; faddr = '0; lat = 1;
        while (!rsp_valid && lat < 60) begin
            if (mem_req) begin filled = 1'b1; faddr = mem_addr; end
            @(negedge clk);
            lat++;
        end
        hit = rsp_hit; rd = rsp_rdata;
        @(negedge clk);
        pulse_ok = !rsp_valid;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic        h, f, p;
        logic [31:0] d, fa, expd;
        int          lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(req_ready == 1'b1, "R10", "ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10", "no response after reset", 32'(rsp_valid), 32'd0);
        chk(mem_req == 1'b0, "R11", "no refill after reset", 32'(mem_req), 32'd0);
        chk(cache_unusable == 1'b0, "R9", "flag clear after reset", 32'(cache_unusable), 32'd0);

        // R3: address 0 with a zero tag still misses
        access(1'b0, 32'h0, 32'h0, h, d, f, fa, lat, p);
        chk(h == 1'b0 && f == 1'b1, "R3", "first access misses", 32'(h), 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, h, d, f, fa, lat, p);
            chk(h == VECS[i].hit, "R1/R2/R4-R8", $sformatf("vec %0d hit", i), 32'(h), 32'(VECS[i].hit));
            chk(f == !VECS[i].hit, "R1/R6", $sformatf("vec %0d refill", i), 32'(f), 32'(!VECS[i].hit));
            chk(lat == (VECS[i].hit ? 2 : 3 + MEM_LAT), "R10", $sformatf("vec %0d latency", i),
                32'(lat), 32'(VECS[i].hit ? 2 : 3 + MEM_LAT));
            chk(p, "R10", $sformatf("vec %0d pulse", i), 32'(p), 32'd1);
            if (f) chk(fa == {VECS[i].addr[31:5], 5'b0}, "R1", $sformatf("vec %0d refill address", i),
                       fa, {VECS[i].addr[31:5], 5'b0});
            if (!VECS[i].we) begin
                expd = VECS[i].use_mw ? mw(VECS[i].addr) : VECS[i].data;
                chk(d == expd, "R1/R2/R7/R8", $sformatf("vec %0d read data", i), d, expd);
            end
        end
        chk(cache_unusable == 1'b0, "R9", "flag clear on healthy rows", 32'(cache_unusable), 32'd0);

        // R9: dead row 9
        access(1'b0, ad(TA, 9, 2, 0), 32'h0, h, d, f, fa, lat, p);
        chk(h == 1'b0, "R9", "dead row no hit", 32'(h), 32'd0);
        chk(f == 1'b0, "R9", "dead row no refill", 32'(f), 32'd0);
        chk(lat == 1, "R10", "dead row latency", 32'(lat), 32'd1);
        chk(cache_unusable == 1'b1, "R9", "flag set", 32'(cache_unusable), 32'd1);
        access(1'b0, ad(TA, 1, 1, 0), 32'h0, h, d, f, fa, lat, p);
        chk(h == 1'b1 && d == mw(ad(TA, 1, 1, 0)), "R9", "healthy row still served", d, mw(ad(TA, 1, 1, 0)));
        chk(cache_unusable == 1'b1, "R9", "flag sticky", 32'(cache_unusable), 32'd1);

        // R3: reset invalidates previously hitting block
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(cache_unusable == 1'b0, "R9", "flag cleared by reset", 32'(cache_unusable), 32'd0);
        access(1'b0, ad(TB, 1, 0, 3), 32'h0, h, d, f, fa, lat, p);
        chk(h == 1'b0 && f == 1'b1, "R3", "miss after reset", 32'(h), 32'd0);
        chk(d == mw(ad(TB, 1, 0, 3)), "R3", "refill data after reset", d, mw(ad(TB, 1, 0, 3)));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule